// File: doc/BRIEF.md
# Gated Frequency Measurement Phase Sequencer

This block produces the control timing for a gated frequency measurement. A fast reference clock is divided by a fixed ratio into a one-clock-wide timebase tick. With the default ratio of 10,000,000 and a 10 MHz reference, that tick arrives once per second. A phase ring advances by one position on each tick. It steps through three phases: counting, latching and clearing. After clearing it returns at once to counting.

Each phase drives one output, and that output is high for exactly one tick period. The gate output is therefore a full-period level, not a square wave at the tick rate. While the gate is high, an external pulse counter accumulates input edges. The latch output then tells the display holding register to capture the finished count. The clear output finally zeroes the pulse counter before the next gate opens. A synchronous reset puts the ring in the clearing phase, so that the first gate starts from a cleared counter.

Top module: `fcs_gate_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `cnt_clr`=1, `gate_en`=0, `latch_upd`=0.
- R2: At every sampled cycle, exactly one of `gate_en`, `latch_upd`, `cnt_clr` is high.
- R3: The active output changes only at every DIV_RATIO-th rising edge counted from reset release. Each phase therefore lasts exactly DIV_RATIO clock cycles.
- R4: The phase order is gate (`gate_en`), then latch (`latch_upd`), then clear (`cnt_clr`), then gate again. No other state is ever visible.
- R5: Each gate window is one contiguous run of exactly DIV_RATIO cycles with `gate_en` high.
- R6: After reset release, `cnt_clr` stays high for DIV_RATIO cycles. `gate_en` rises after the DIV_RATIO-th rising edge.
- R7: If reset is high in the same cycle as a timebase tick, reset wins. The ring goes to the clear phase, and the divider restarts a full DIV_RATIO period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_en | output | 1 | High for one tick period while input pulses are to be counted |
| latch_upd | output | 1 | High for one tick period while the display register captures the count |
| cnt_clr | output | 1 | High for one tick period while the pulse counter is cleared |

## Verification
A timebase tick and a synchronous reset can fall in the same cycle, and those two functions then compete for the phase ring. The bench raises reset in exactly the cycle where the divider sits at its terminal value during a gate phase. It then checks that the outputs show the clear phase rather than the latch phase. It also checks that the next gate opens only after a full, fresh divide period from the reset release.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [2:0] {
        PH_COUNT = 3'b001,
        PH_LATCH = 3'b010,
        PH_CLEAR = 3'b100
    } phase_e;

    typedef struct packed {
        logic gate;
        logic latch;
        logic clear;
    } ctrl_t;

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_COUNT: return PH_LATCH;
            PH_LATCH: return PH_CLEAR;
            default:  return PH_COUNT;
        endcase
    endfunction

    function automatic ctrl_t decode_phase(input phase_e p);
        ctrl_t c;
        c.gate  = (p == PH_COUNT);
        c.latch = (p == PH_LATCH);
        c.clear = (p == PH_CLEAR);
        return c;
    endfunction

endpackage

// File: rtl/fcs_tick_divider.sv
module fcs_tick_divider #(
    parameter int DIV_RATIO = 10_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // R3: the divide count never leaves its range
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R7: a fresh period starts after reset
    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt == '0));

    // R3: the tick is followed by a wrapped count
    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));

endmodule

// File: rtl/fcs_phase_ring.sv
module fcs_phase_ring
    import fcs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    output ctrl_t  ctrl
);
    phase_e phase;

    always_ff @(posedge clk) begin
        if (rst)
            phase <= PH_CLEAR;
        else if (tick)
            phase <= next_phase(phase);
    end

    assign ctrl = decode_phase(phase);

    // R2: one phase at a time
    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(phase) == 1);

    // R1: reset leaves the ring in the clear phase
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (phase == PH_CLEAR));

    // R3: without a tick the phase holds
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(phase));

    // R4: fixed order count -> latch -> clear -> count
    assert_cnt_to_lat_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && phase == PH_COUNT) |=> (phase == PH_LATCH));
    assert_lat_to_clr_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && phase == PH_LATCH) |=> (phase == PH_CLEAR));
    assert_clr_to_cnt_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && phase == PH_CLEAR) |=> (phase == PH_COUNT));

endmodule

// File: rtl/fcs_gate_sequencer.sv
module fcs_gate_sequencer
    import fcs_pkg::*;
#(
    parameter int DIV_RATIO = 10_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic gate_en,
    output logic latch_upd,
    output logic cnt_clr
);
    localparam int RUN_W = $clog2(DIV_RATIO + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(DIV_RATIO);

    logic  tick;
    ctrl_t ctrl;

    fcs_tick_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    fcs_phase_ring u_ring (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .ctrl (ctrl)
    );

    assign gate_en   = ctrl.gate;
    assign latch_upd = ctrl.latch;
    assign cnt_clr   = ctrl.clear;

    // checker: length of the current gate window
    logic [RUN_W-1:0] gate_run;
    always_ff @(posedge clk) begin
        if (rst || !gate_en)
            gate_run <= '0;
        else if (gate_run != RUN_FULL)
            gate_run <= gate_run + 1'b1;
    end

    // R5: a gate window closes only after exactly DIV_RATIO cycles
    assert_gate_width_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(gate_en) && !$past(rst)) |-> (gate_run == RUN_FULL));

    // R4: latch only ever follows a completed gate
    assert_latch_after_gate_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(latch_upd) && !$past(rst)) |-> $past(gate_en));

endmodule

// File: tb/test_fcs_gate_sequencer.sv
module test_fcs_gate_sequencer;

    localparam int DIV = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gate_en, latch_upd, cnt_clr;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    fcs_gate_sequencer #(.DIV_RATIO(DIV)) i_fcs_gate_sequencer (
        .clk       (clk),
        .rst       (rst),
        .gate_en   (gate_en),
        .latch_upd (latch_upd),
        .cnt_clr   (cnt_clr)
    );

    // outputs packed as {gate, latch, clear}
    localparam int VEC_N = 8;
    localparam int VEC_AT  [VEC_N] = '{0, 4, 5, 9, 10, 14, 15, 20};
    localparam int VEC_EXP [VEC_N] = '{1, 1, 4, 4, 2, 2, 1, 4};

    int since;

    task automatic chk(input string tag, input int exp);
        logic [2:0] act;
        act = {gate_en, latch_upd, cnt_clr};
        checks++;
        if (act != 3'(exp)) begin
            fails++;
            $display("FAIL %s: outputs act=%b exp=%b (edges since release %0d)",
                     tag, act, 3'(exp), since);
        end
        checks++;
        if ($countones(act) != 1) begin
            fails++;
            $display("FAIL R2: onehot act=%b exp=one bit set", act);
        end
    endtask

    task automatic step();
        @(negedge clk);
        since++;
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        int run;
        since = 0;
        // R1: reset held over several edges
        repeat (3) begin
            @(negedge clk);
            chk("R1", 1);
        end
        rst = 1'b0;
        since = 0;

        // table walk: R3 R4 R6
        for (int i = 0; i < VEC_N; i++) begin
            while (since < VEC_AT[i]) step();
            chk((i == 2) ? "R6" : "R4/R3", VEC_EXP[i]);
        end

        // R5: gate window width
        run = 0;
        while (gate_en && run < 3 * DIV) begin
            run++;
            step();
        end
        checks++;
        if (run != DIV) begin
            fails++;
            $display("FAIL R5: gate width act=%0d exp=%0d", run, DIV);
        end
        chk("R4", 2);

        // R7: reset coinciding with a tick during the gate phase
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        since = 0;
        @(negedge clk);
        since = 0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        since = 0;
        while (since < 2 * DIV - 1) step();
        chk("R4", 4);
        rst = 1'b1;
        @(negedge clk);
        chk("R7", 1);
        rst = 1'b0;
        since = 0;
        while (since < DIV - 1) step();
        chk("R7", 1);
        step();
        chk("R7", 4);

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule